// File: doc/BRIEF.md
# DS3 Bipolar Line Decoder with Violation and Signal-Loss Monitoring

This block sits right after the line receiver of a DS3 port. Each cycle of the recovered bit clock it takes one bipolar symbol, carried as two pulse strobes: one for a positive mark and one for a negative mark. It turns these into a single NRZ data bit. In B3ZS mode it removes the three-bit zero-substitution codes the far end inserted. If the mode input is set, it does plain AMI decoding instead and no substitution is removed.

Alongside the data the block produces three monitors:
- a per-symbol strobe for bipolar violations that do not belong to a legal substitution;
- a per-symbol strobe for zero runs longer than the selected code allows;
- a loss-of-signal level, declared after a long run of zeros and cleared only after a shorter but unbroken run of marks.

The loss-of-signal monitor can be switched off. While it is off, the level stays low.

Top module: `ds3_line_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `data_o`, `lcv_o`, `exz_o` and `los_o` are all 0.
- R2: A symbol is a mark when `pos_i` or `neg_i` is 1, and a zero when both are 0. The decoded bit for the symbol sampled at clock edge t appears on `data_o` after edge t+2, so the latency is three edges. With no substitution, a mark decodes to 1 and a zero decodes to 0.
- R3: With `ami_mode_i`=0 (B3ZS), the pattern B0V decodes to three 0 bits. Here B is a non-violating mark, then comes a zero, then V, a mark with the same polarity as the previous mark. No LCV is raised for V.
- R4: With `ami_mode_i`=0, the pattern 00V decodes to three 0 bits: two zeros, then a mark with the same polarity as the last mark. No LCV is raised for V.
- R5: With `ami_mode_i`=1 (AMI), no substitution is removed. Every violating mark decodes to 1 and raises `lcv_o`.
- R6: `lcv_o` pulses after edge t when symbol t is a same-polarity mark that is not the final mark of a legal substitution. A zero never raises it. The first single-rail mark after reset is never a violation. Any violating mark sets the reference polarity for the next mark.
- R7: A symbol with both rails at 1 raises `lcv_o`, decodes to 1, and leaves the reference polarity unchanged.
- R8: With `ami_mode_i`=0, `exz_o` pulses after edge t when symbol t is a zero that makes the current run of consecutive line zeros 3 or more long. A mark never raises it.
- R9: With `ami_mode_i`=1, `exz_o` pulses for each zero that makes the zero run 16 or more long.
- R10: `los_o` rises after the edge that samples the 180th consecutive zero symbol. Marks never set it.
- R11: A set `los_o` clears after the edge that samples the 60th consecutive mark symbol. A zero inside the run restarts the count and does not clear it.
- R12: While `los_disable_i`=1, `los_o` is 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 1 | Positive-mark strobe |
| neg_i | input | 1 | Negative-mark strobe |
| ami_mode_i | input | 1 | 1 = plain AMI, 0 = B3ZS substitution removal |
| los_disable_i | input | 1 | 1 forces the loss-of-signal level low |
| data_o | output | 1 | Decoded NRZ data, three edges after the symbol |
| lcv_o | output | 1 | Line code violation strobe, one edge after the symbol |
| exz_o | output | 1 | Excessive-zero strobe, one edge after the symbol |
| los_o | output | 1 | Loss-of-signal level |

## Verification
The bench builds the block with its default parameters:
- excessive-zero limits of 3 (B3ZS) and 16 (AMI);
- a loss-of-signal declare threshold of 180 zeros and a clear threshold of 60 marks.

These are the operating values themselves, and the run-length counters reach them in a few hundred cycles. So the exact crossings can be checked: the 179th versus 180th zero, the 59th versus 60th mark, and the 15th versus 16th AMI zero. Because the threshold is exact, an off-by-one in any counter shows up at the output.

// File: rtl/ds3_b3zs_pkg.sv
package ds3_b3zs_pkg;

    // Length of one zero-substitution code on the line.
    localparam int SUB_LEN = 3;

    // Class of a line symbol, remembered for substitution detection.
    typedef enum logic [1:0] {
        SYM_ZERO  = 2'd0,
        SYM_MARK  = 2'd1,
        SYM_OTHER = 2'd2
    } sym_t;

    // Per-symbol decode result handed from the classifier to the rest.
    typedef struct packed {
        logic bit_val;
        logic mark;
        logic lcv;
        logic sub;
    } dec_t;

    // A violation ends a legal code when the two symbols before it
    // were zero-zero or normal-mark-then-zero.
    function automatic logic sub_window_ok(sym_t h1, sym_t h2);
        return (h1 == SYM_ZERO) && ((h2 == SYM_ZERO) || (h2 == SYM_MARK));
    endfunction

endpackage

// File: rtl/b3zs_symbol_classifier.sv
module b3zs_symbol_classifier
    import ds3_b3zs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    input  logic b3zs_en_i,
    output dec_t dec_o
);

    logic seen_q;
    logic last_pos_q;
    sym_t h1_q;
    sym_t h2_q;

    logic single;
    logic mark;
    logic viol;
    logic sub;
    sym_t cls;

    always_comb begin
        single = pos_i ^ neg_i;
        mark   = pos_i | neg_i;
        viol   = single && seen_q && (pos_i == last_pos_q);
        sub    = b3zs_en_i && viol && sub_window_ok(h1_q, h2_q);

        dec_o.bit_val = mark && !sub;
        dec_o.mark    = mark;
        dec_o.lcv     = (pos_i && neg_i) || (viol && !sub);
        dec_o.sub     = sub;

        if (!mark)
            cls = SYM_ZERO;
        else if (single && !viol)
            cls = SYM_MARK;
        else
            cls = SYM_OTHER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_pos_q <= 1'b0;
            h1_q       <= SYM_OTHER;
            h2_q       <= SYM_OTHER;
        end else begin
            h2_q <= h1_q;
            h1_q <= cls;
            if (single) begin
                seen_q     <= 1'b1;
                last_pos_q <= pos_i;
            end
        end
    end

endmodule

// File: rtl/b3zs_data_pipe.sv
module b3zs_data_pipe #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic sub_i,
    output logic data_o
);

    logic [LEN-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (sub_i)
            stage_q <= '0;
        else
            stage_q <= {stage_q[LEN-2:0], bit_i};
    end

    assign data_o = stage_q[LEN-1];

endmodule

// File: rtl/b3zs_run_monitor.sv
module b3zs_run_monitor #(
    parameter int EXZ_B3ZS    = 3,
    parameter int EXZ_AMI     = 16,
    parameter int LOS_DECLARE = 180,
    parameter int LOS_CLEAR   = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic mark_i,
    input  logic ami_mode_i,
    input  logic los_disable_i,
    output logic exz_o,
    output logic los_o
);

    localparam int ZMAX = (LOS_DECLARE > EXZ_AMI) ? LOS_DECLARE : EXZ_AMI;
    localparam int ZW   = $clog2(ZMAX + 1);
    localparam int MW   = $clog2(LOS_CLEAR + 1);

    logic [ZW-1:0] zrun_q, zrun_nxt;
    logic [MW-1:0] mrun_q, mrun_nxt;
    logic [ZW-1:0] exz_lim;
    logic          exz_q;
    logic          los_q;

    always_comb begin
        zrun_nxt = (zrun_q == ZW'(ZMAX)) ? zrun_q : zrun_q + 1'b1;
        mrun_nxt = (mrun_q == MW'(LOS_CLEAR)) ? mrun_q : mrun_q + 1'b1;
        exz_lim  = ami_mode_i ? ZW'(EXZ_AMI) : ZW'(EXZ_B3ZS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun_q <= '0;
            mrun_q <= '0;
            exz_q  <= 1'b0;
            los_q  <= 1'b0;
        end else begin
            if (mark_i) begin
                zrun_q <= '0;
                mrun_q <= mrun_nxt;
                exz_q  <= 1'b0;
            end else begin
                zrun_q <= zrun_nxt;
                mrun_q <= '0;
                exz_q  <= (zrun_nxt >= exz_lim);
            end

            if (los_disable_i)
                los_q <= 1'b0;
            else if (!mark_i && (zrun_nxt >= ZW'(LOS_DECLARE)))
                los_q <= 1'b1;
            else if (mark_i && (mrun_nxt >= MW'(LOS_CLEAR)))
                los_q <= 1'b0;
        end
    end

    assign exz_o = exz_q;
    assign los_o = los_q;

    // R10: a mark never raises the loss-of-signal level
    assert_mark_no_los_rise_R10: assert property (@(posedge clk) disable iff (rst)
        mark_i |=> !$rose(los_q));

    // R11: a zero never clears a set loss-of-signal level
    assert_zero_keeps_los_R11: assert property (@(posedge clk) disable iff (rst)
        (!mark_i && !los_disable_i && los_q) |=> los_q);

endmodule

// File: rtl/ds3_line_decoder.sv
module ds3_line_decoder
    import ds3_b3zs_pkg::*;
#(
    parameter int EXZ_B3ZS    = 3,
    parameter int EXZ_AMI     = 16,
    parameter int LOS_DECLARE = 180,
    parameter int LOS_CLEAR   = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    input  logic ami_mode_i,
    input  logic los_disable_i,
    output logic data_o,
    output logic lcv_o,
    output logic exz_o,
    output logic los_o
);

    dec_t dec;
    logic lcv_q;

    b3zs_symbol_classifier u_class (
        .clk       (clk),
        .rst       (rst),
        .pos_i     (pos_i),
        .neg_i     (neg_i),
        .b3zs_en_i (!ami_mode_i),
        .dec_o     (dec)
    );

    b3zs_data_pipe #(.LEN(SUB_LEN)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (dec.bit_val),
        .sub_i  (dec.sub),
        .data_o (data_o)
    );

    b3zs_run_monitor #(
        .EXZ_B3ZS    (EXZ_B3ZS),
        .EXZ_AMI     (EXZ_AMI),
        .LOS_DECLARE (LOS_DECLARE),
        .LOS_CLEAR   (LOS_CLEAR)
    ) u_mon (
        .clk           (clk),
        .rst           (rst),
        .mark_i        (dec.mark),
        .ami_mode_i    (ami_mode_i),
        .los_disable_i (los_disable_i),
        .exz_o         (exz_o),
        .los_o         (los_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lcv_q <= 1'b0;
        else
            lcv_q <= dec.lcv;
    end

    assign lcv_o = lcv_q;

    // R7: both rails at once is always a violation
    assert_both_rails_lcv_R7: assert property (@(posedge clk) disable iff (rst)
        (pos_i && neg_i) |=> lcv_o);

    // R6: a zero symbol never raises a violation
    assert_zero_no_lcv_R6: assert property (@(posedge clk) disable iff (rst)
        !(pos_i || neg_i) |=> !lcv_o);

    // R8: a mark never raises the excessive-zero strobe
    assert_mark_no_exz_R8: assert property (@(posedge clk) disable iff (rst)
        (pos_i || neg_i) |=> !exz_o);

    // R2: a zero on the line leaves the pipeline as a zero
    assert_zero_decodes_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !(pos_i || neg_i) |=> ##2 !data_o);

    // R12: disabling the monitor drops the level
    assert_los_disabled_R12: assert property (@(posedge clk) disable iff (rst)
        los_disable_i |=> !los_o);

endmodule

// File: tb/ds3_line_decoder_bench.sv
module ds3_line_decoder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos_i = 1'b0;
    logic neg_i = 1'b0;
    logic ami_mode_i = 1'b0;
    logic los_disable_i = 1'b0;
    logic data_o, lcv_o, exz_o, los_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ds3_line_decoder u_ds3_line_decoder (
        .clk           (clk),
        .rst           (rst),
        .pos_i         (pos_i),
        .neg_i         (neg_i),
        .ami_mode_i    (ami_mode_i),
        .los_disable_i (los_disable_i),
        .data_o        (data_o),
        .lcv_o         (lcv_o),
        .exz_o         (exz_o),
        .los_o         (los_o)
    );

    // {pos, neg, expected bit, expected lcv, expected exz}, B3ZS mode
    localparam int NV = 23;
    localparam logic [4:0] VEC [NV] = '{
        5'b10100, 5'b01100, 5'b00000, 5'b00000, 5'b01000,  // R4 00V at 4
        5'b10000, 5'b00000, 5'b10000,                      // R3 B0V at 7
        5'b01100, 5'b01110,                                // R6 stray violation
        5'b10100, 5'b00000, 5'b00000, 5'b00001, 5'b00001,  // R8 run of 3,4
        5'b10000,                                          // R4 00V at 15
        5'b11110,                                          // R7 both rails
        5'b10110,                                          // R7 polarity kept
        5'b01000, 5'b00000, 5'b01000,                      // R3 B0V at 20
        5'b00000, 5'b00000
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(input logic p, input logic n);
        pos_i = p;
        neg_i = n;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pos_i = 1'b0;
        neg_i = 1'b0;
        los_disable_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 data", data_o, 1'b0);
        chk("R1 lcv", lcv_o, 1'b0);
        chk("R1 exz", exz_o, 1'b0);
        chk("R1 los", los_o, 1'b0);
        tick(1'b0, 1'b0);
        chk("R1 data after release", data_o, 1'b0);
        chk("R1 los after release", los_o, 1'b0);

        // Vector walk in B3ZS mode: R2 R3 R4 R6 R7 R8
        do_reset();
        ami_mode_i = 1'b0;
        for (int i = 0; i < NV; i++) begin
            tick(VEC[i][4], VEC[i][3]);
            chk("R6 lcv vector", lcv_o, VEC[i][1]);
            chk("R8 exz vector", exz_o, VEC[i][0]);
            if (i >= 2)
                chk("R2/R3/R4 data vector", data_o, VEC[i-2][2]);
        end
        tick(1'b0, 1'b0);
        chk("R2 data tail", data_o, VEC[NV-2][2]);
        tick(1'b0, 1'b0);
        chk("R2 data tail", data_o, VEC[NV-1][2]);

        // R5 and R9: AMI mode
        do_reset();
        ami_mode_i = 1'b1;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        chk("R5 violation flagged in AMI", lcv_o, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        chk("R5 violation decoded as one", data_o, 1'b1);
        for (int k = 3; k <= 17; k++) begin
            tick(1'b0, 1'b0);
            chk("R9 AMI zero limit", exz_o, (k >= 16));
        end
        ami_mode_i = 1'b0;

        // R10 and R11: loss of signal
        do_reset();
        for (int i = 1; i <= 180; i++) begin
            tick(1'b0, 1'b0);
            if (i == 179) chk("R10 no LOS at 179 zeros", los_o, 1'b0);
            if (i == 180) chk("R10 LOS at 180 zeros", los_o, 1'b1);
        end
        for (int i = 1; i <= 59; i++) tick(i[0], !i[0]);
        chk("R11 LOS held at 59 marks", los_o, 1'b1);
        tick(1'b0, 1'b0);
        chk("R11 LOS held after broken run", los_o, 1'b1);
        for (int i = 1; i <= 60; i++) begin
            tick(i[0], !i[0]);
            if (i == 59) chk("R11 LOS held at 59 marks again", los_o, 1'b1);
            if (i == 60) chk("R11 LOS cleared at 60 marks", los_o, 1'b0);
        end

        // R12: monitor disable
        for (int i = 1; i <= 180; i++) tick(1'b0, 1'b0);
        chk("R12 LOS set before disable", los_o, 1'b1);
        los_disable_i = 1'b1;
        tick(1'b0, 1'b0);
        chk("R12 LOS low when disabled", los_o, 1'b0);
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);
        chk("R12 LOS stays low under zeros", los_o, 1'b0);
        los_disable_i = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule